// File: doc/BRIEF.md
# Radio Link Host Message Front-End

This block sits on the radio side of a byte-oriented serial link to a host controller. The host sends framed messages. The first byte of each message selects what the rest means. A configuration message sets the radio's link parameters. A data message passes a payload into a transmit queue that the radio engine drains. A statistics request makes the block return a six-byte report on the host-bound stream. The serial shifter is outside the block and is modelled as a byte strobe.

On the other side, the radio engine pops queued packets one byte at a time. It reports each finished transmission as a pulse: one pulse for success, or one of two failure pulses (channel still busy after the last access attempt, or retransmission limit reached). The block counts failures over windows of 255 transmit outcomes. It also keeps a moving average of the time each transmission takes. Packets received from the network are held in a local queue until the host drains them. This is needed because the host may own the link and cannot be interrupted. The host can use these figures to slow its own data rate while the channel is congested.

Top module: `radio_link_frontend`

## Requirements
- R1: After a synchronous reset, `host_valid` and `txq_valid` are low, and every configuration output is zero.
- R2: Type byte 0x01 starts a configuration message of 11 further bytes, in this order: a flag byte (bits 1:0 role, where 0 is coordinator, 1 is router and 2 is end device; bit 2 acknowledge enable; bit 3 listen when idle), 8 MAC address bytes with the most significant byte first, and 2 network identifier bytes with the most significant byte first. The outputs change only when the final byte arrives.
- R3: When a message is expected, a type byte other than 0x01 to 0x03 is ignored. The configuration does not change and the next byte is taken as a new type byte.
- R4: Type byte 0x02 is followed by a length byte L and then L payload bytes, which enter the transmit queue in order. `txq_last` marks the final byte of the packet. `txq_valid` stays low until the whole packet is stored. L = 0 queues nothing.
- R5: If L is larger than the free space in the transmit queue, the whole message is consumed and dropped, and an overflow flag is set. The flag appears as bit 0 of the sixth response byte and clears once it has been reported.
- R6: Type byte 0x03 produces a response on the host stream of six bytes: 0x04, the failure count of the last completed window, the number of complete packets in the transmit queue, the average delay high byte, the average delay low byte, and the flag byte. The sixth byte carries `host_last`.
- R7: Every outcome pulse counts as one request. Either failure pulse also counts as one failure. On the 255th request, the window value becomes the failure count including that request, and both counters clear. Between windows, the reported value holds.
- R8: The delay is the number of clock cycles from the cycle in which the first byte of a packet is popped to the cycle in which its outcome pulse arrives. On each outcome, the average becomes floor((7*avg + delay)/8), starting from 0.
- R9: Bytes from the network (`net_valid`, `net_byte`, `net_last`) reach the host in arrival order, each with its last flag.
- R10: A response never interleaves with a network packet that has been partly read. It waits for that packet's last byte, and then takes priority over further queued network bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe for a byte from the host |
| rx_byte | input | 8 | Byte from the host |
| host_valid | output | 1 | A host-bound byte is available |
| host_byte | output | 8 | Host-bound byte |
| host_last | output | 1 | Final byte of the host-bound unit |
| host_rd | input | 1 | Host takes the current byte |
| net_valid | input | 1 | Strobe for a byte received from the network |
| net_byte | input | 8 | Network byte |
| net_last | input | 1 | Final byte of the network packet |
| txq_valid | output | 1 | A complete packet is queued for transmission |
| txq_byte | output | 8 | Head byte of the transmit queue |
| txq_last | output | 1 | Head byte ends its packet |
| txq_pop | input | 1 | Radio engine takes the head byte |
| tx_ok | input | 1 | Pulse: transmission completed |
| tx_fail_busy | input | 1 | Pulse: channel busy after the last access attempt |
| tx_fail_retry | input | 1 | Pulse: retransmission limit reached |
| cfg_role | output | 2 | Node role |
| cfg_ack_en | output | 1 | Acknowledge enable |
| cfg_listen | output | 1 | Listen when idle |
| cfg_mac | output | 64 | MAC address |
| cfg_netid | output | 16 | Network identifier |

## Verification
The hardest case to reach is the window rollover. It needs exactly 255 outcomes with known failure positions, and the report must hold its old value for all 254 outcomes before the rollover. The bench drives single-cycle outcome pulses in a loop, reads a report just before the 255th outcome, and reads another just after it. A second hard case is a report requested in the middle of a network packet. The bench reads one byte of a three-byte network packet, then requests statistics, and expects the other two network bytes before the report.

// File: rtl/rlf_pkg.sv
package rlf_pkg;
  localparam logic [7:0] TYPE_CFG  = 8'h01;
  localparam logic [7:0] TYPE_DATA = 8'h02;
  localparam logic [7:0] TYPE_SREQ = 8'h03;
  localparam logic [7:0] TYPE_SRSP = 8'h04;
  localparam logic [7:0] CFG_LAST  = 8'd10;  // index of final config body byte
  localparam int         RESP_BYTES = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_LEN, ST_PAY, ST_DROP
  } pstate_t;
endpackage

// File: rtl/rlf_byte_fifo.sv
module rlf_byte_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rlf_msg_parser.sv
module rlf_msg_parser import rlf_pkg::*; #(
  parameter int FREE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [FREE_W-1:0] txq_free,
  output logic              txq_wr,
  output logic [7:0]        txq_data,
  output logic              txq_last,
  output logic              pkt_commit,
  output logic              ovf_set,
  output logic              stats_req,
  output logic [1:0]        cfg_role,
  output logic              cfg_ack_en,
  output logic              cfg_listen,
  output logic [63:0]       cfg_mac,
  output logic [15:0]       cfg_netid
);
  localparam int CW = (FREE_W > 8) ? FREE_W : 8;

  pstate_t     st;
  logic [7:0]  cnt;
  logic [3:0]  sh_flags;
  logic [63:0] sh_mac;
  logic [7:0]  sh_net_hi;
  logic        fits;

  assign fits = CW'(rx_byte) <= CW'(txq_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;
      txq_wr <= 1'b0; txq_data <= '0; txq_last <= 1'b0;
      pkt_commit <= 1'b0; ovf_set <= 1'b0; stats_req <= 1'b0;
      sh_flags <= '0; sh_mac <= '0; sh_net_hi <= '0;
      cfg_role <= '0; cfg_ack_en <= 1'b0; cfg_listen <= 1'b0;
      cfg_mac <= '0; cfg_netid <= '0;
    end else begin
      txq_wr <= 1'b0; txq_last <= 1'b0; pkt_commit <= 1'b0;
      ovf_set <= 1'b0; stats_req <= 1'b0;
      if (rx_valid) begin
        case (st)
          ST_IDLE: begin
            case (rx_byte)
              TYPE_CFG:  begin st <= ST_CFG; cnt <= '0; end
              TYPE_DATA: st <= ST_LEN;
              TYPE_SREQ: stats_req <= 1'b1;
              default:   st <= ST_IDLE;
            endcase
          end
          ST_CFG: begin
            cnt <= cnt + 1'b1;
            if (cnt == 8'd0)       sh_flags <= rx_byte[3:0];
            else if (cnt <= 8'd8)  sh_mac <= {sh_mac[55:0], rx_byte};
            else if (cnt < CFG_LAST) sh_net_hi <= rx_byte;
            else begin
              cfg_role   <= sh_flags[1:0];
              cfg_ack_en <= sh_flags[2];
              cfg_listen <= sh_flags[3];
              cfg_mac    <= sh_mac;
              cfg_netid  <= {sh_net_hi, rx_byte};
              st         <= ST_IDLE;
            end
          end
          ST_LEN: begin
            cnt <= rx_byte;
            if (rx_byte == 8'd0) st <= ST_IDLE;
            else if (fits)       st <= ST_PAY;
            else begin
              st      <= ST_DROP;
              ovf_set <= 1'b1;
            end
          end
          ST_PAY: begin
            txq_wr   <= 1'b1;
            txq_data <= rx_byte;
            cnt      <= cnt - 1'b1;
            if (cnt == 8'd1) begin
              txq_last   <= 1'b1;
              pkt_commit <= 1'b1;
              st         <= ST_IDLE;
            end
          end
          ST_DROP: begin
            cnt <= cnt - 1'b1;
            if (cnt == 8'd1) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rlf_link_stats.sv
module rlf_link_stats #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_ok,
  input  logic              tx_fail_busy,
  input  logic              tx_fail_retry,
  input  logic              tx_start,
  output logic [7:0]        fail_window,
  output logic [TICK_W-1:0] avg_delay
);
  logic [TICK_W-1:0] tick, t_start, delay;
  logic [7:0]        req_cnt, fail_cnt;
  logic              failed, done;
  logic [TICK_W+2:0] ema_sum;

  assign failed  = tx_fail_busy | tx_fail_retry;
  assign done    = tx_ok | failed;
  assign delay   = tick - t_start;
  assign ema_sum = {avg_delay, 3'b000} - {3'b000, avg_delay} + {3'b000, delay};

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0; t_start <= '0;
      req_cnt <= '0; fail_cnt <= '0;
      fail_window <= '0; avg_delay <= '0;
    end else begin
      tick <= tick + 1'b1;
      if (tx_start) t_start <= tick;
      if (done) begin
        avg_delay <= ema_sum[TICK_W+2:3];
        if (req_cnt == 8'd254) begin
          fail_window <= fail_cnt + {7'd0, failed};
          req_cnt     <= '0;
          fail_cnt    <= '0;
        end else begin
          req_cnt  <= req_cnt + 1'b1;
          fail_cnt <= fail_cnt + {7'd0, failed};
        end
      end
    end
  end
endmodule

// File: rtl/radio_link_frontend.sv
module radio_link_frontend import rlf_pkg::*; #(
  parameter int TXQ_DEPTH = 64,
  parameter int RXQ_DEPTH = 32,
  parameter int TICK_W    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        host_valid,
  output logic [7:0]  host_byte,
  output logic        host_last,
  input  logic        host_rd,
  input  logic        net_valid,
  input  logic [7:0]  net_byte,
  input  logic        net_last,
  output logic        txq_valid,
  output logic [7:0]  txq_byte,
  output logic        txq_last,
  input  logic        txq_pop,
  input  logic        tx_ok,
  input  logic        tx_fail_busy,
  input  logic        tx_fail_retry,
  output logic [1:0]  cfg_role,
  output logic        cfg_ack_en,
  output logic        cfg_listen,
  output logic [63:0] cfg_mac,
  output logic [15:0] cfg_netid
);
  localparam int TXQ_AW = $clog2(TXQ_DEPTH);
  localparam int RXQ_AW = $clog2(RXQ_DEPTH);
  localparam int FREE_W = TXQ_AW + 1;
  localparam int IDX_W  = $clog2(RESP_BYTES);

  logic              txq_wr, txq_wlast, pkt_commit, ovf_set, stats_req;
  logic [7:0]        txq_wdata;
  logic [8:0]        txq_rd_data, rxq_rd_data;
  logic              txq_empty, txq_full, rxq_empty, rxq_full;
  logic [TXQ_AW:0]   txq_level;
  logic [RXQ_AW:0]   rxq_level;
  logic [FREE_W-1:0] txq_free;
  logic [TXQ_AW:0]   pkt_cnt;
  logic              tx_in_pkt, tx_take, tx_start;
  logic [7:0]        fail_window;
  logic [TICK_W-1:0] avg_delay;
  logic              ovf_flag, resp_active, net_mid, sel_resp, rxq_take;
  logic [IDX_W-1:0]  resp_idx;
  logic [7:0]        resp_buf [RESP_BYTES];
  logic [7:0]        qcount;

  assign txq_free = FREE_W'(TXQ_DEPTH) - txq_level;

  rlf_msg_parser #(.FREE_W(FREE_W)) u_parser (
    .clk, .rst, .rx_valid, .rx_byte, .txq_free,
    .txq_wr, .txq_data(txq_wdata), .txq_last(txq_wlast),
    .pkt_commit, .ovf_set, .stats_req,
    .cfg_role, .cfg_ack_en, .cfg_listen, .cfg_mac, .cfg_netid
  );

  rlf_byte_fifo #(.W(9), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk, .rst, .wr_en(txq_wr), .wr_data({txq_wlast, txq_wdata}),
    .rd_en(tx_take), .rd_data(txq_rd_data),
    .empty(txq_empty), .full(txq_full), .level(txq_level)
  );

  rlf_byte_fifo #(.W(9), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk, .rst, .wr_en(net_valid), .wr_data({net_last, net_byte}),
    .rd_en(rxq_take), .rd_data(rxq_rd_data),
    .empty(rxq_empty), .full(rxq_full), .level(rxq_level)
  );

  rlf_link_stats #(.TICK_W(TICK_W)) u_stats (
    .clk, .rst, .tx_ok, .tx_fail_busy, .tx_fail_retry, .tx_start,
    .fail_window, .avg_delay
  );

  // transmit side: only whole packets are exposed
  assign txq_valid = (pkt_cnt != '0);
  assign txq_byte  = txq_rd_data[7:0];
  assign txq_last  = txq_rd_data[8];
  assign tx_take   = txq_pop && txq_valid;
  assign tx_start  = tx_take && !tx_in_pkt;
  assign qcount    = (pkt_cnt > (TXQ_AW+1)'(255)) ? 8'hFF : 8'(pkt_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_cnt   <= '0;
      tx_in_pkt <= 1'b0;
    end else begin
      case ({pkt_commit, tx_take && txq_last})
        2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
        2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
        default: pkt_cnt <= pkt_cnt;
      endcase
      if (tx_take) tx_in_pkt <= !txq_last;
    end
  end

  // host side: response or network bytes, switched only on packet edges
  assign sel_resp   = resp_active && !net_mid;
  assign host_valid = sel_resp || !rxq_empty;
  assign host_byte  = sel_resp ? resp_buf[resp_idx] : rxq_rd_data[7:0];
  assign host_last  = sel_resp ? (resp_idx == IDX_W'(RESP_BYTES-1)) : rxq_rd_data[8];
  assign rxq_take   = host_rd && !sel_resp && !rxq_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag    <= 1'b0;
      resp_active <= 1'b0;
      resp_idx    <= '0;
      net_mid     <= 1'b0;
      for (int i = 0; i < RESP_BYTES; i++) resp_buf[i] <= '0;
    end else begin
      if (ovf_set) ovf_flag <= 1'b1;
      if (rxq_take) net_mid <= !rxq_rd_data[8];
      if (stats_req && !resp_active) begin
        resp_buf[0] <= TYPE_SRSP;
        resp_buf[1] <= fail_window;
        resp_buf[2] <= qcount;
        resp_buf[3] <= avg_delay[TICK_W-1 -: 8];
        resp_buf[4] <= avg_delay[7:0];
        resp_buf[5] <= {7'd0, ovf_flag};
        resp_idx    <= '0;
        resp_active <= 1'b1;
        ovf_flag    <= 1'b0;
      end else if (host_rd && sel_resp) begin
        if (resp_idx == IDX_W'(RESP_BYTES-1)) resp_active <= 1'b0;
        else resp_idx <= resp_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rlf_checker.sv
module rlf_checker #(
  parameter int TICK_W = 16,
  parameter int RXQ_DEPTH = 32,
  localparam int RXQ_AW = $clog2(RXQ_DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              tx_ok,
  input logic              tx_fail_busy,
  input logic              tx_fail_retry,
  input logic [63:0]       cfg_mac,
  input logic [7:0]        fail_window,
  input logic [TICK_W-1:0] avg_delay,
  input logic              txq_wr,
  input logic              txq_full,
  input logic              txq_valid,
  input logic              txq_empty,
  input logic [RXQ_AW:0]   rxq_level
);
  AST_CFG_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_mac) |-> $past(rx_valid));                           // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    txq_wr |-> !txq_full);                                            // R5
  AST_QUEUE_BACKED: assert property (@(posedge clk) disable iff (rst)
    txq_valid |-> !txq_empty);                                        // R4
  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(fail_window) |-> $past(tx_ok | tx_fail_busy | tx_fail_retry)); // R7
  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(avg_delay) |-> $past(tx_ok | tx_fail_busy | tx_fail_retry));   // R8
  AST_RXQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    rxq_level <= (RXQ_AW+1)'(RXQ_DEPTH));                             // R9
endmodule

bind radio_link_frontend rlf_checker #(.TICK_W(TICK_W), .RXQ_DEPTH(RXQ_DEPTH)) u_chk (
  .clk, .rst, .rx_valid, .tx_ok, .tx_fail_busy, .tx_fail_retry,
  .cfg_mac, .fail_window, .avg_delay, .txq_wr, .txq_full,
  .txq_valid, .txq_empty, .rxq_level
);

// File: tb/radio_link_frontend_tb.sv
`timescale 1ns/1ps
module radio_link_frontend_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0; logic [7:0] rx_byte = 0;
  logic host_valid, host_last; logic [7:0] host_byte; logic host_rd = 0;
  logic net_valid = 0, net_last = 0; logic [7:0] net_byte = 0;
  logic txq_valid, txq_last; logic [7:0] txq_byte; logic txq_pop = 0;
  logic tx_ok = 0, tx_fail_busy = 0, tx_fail_retry = 0;
  logic [1:0] cfg_role; logic cfg_ack_en, cfg_listen;
  logic [63:0] cfg_mac; logic [15:0] cfg_netid;
  int vectors = 0, errors = 0;
  logic [7:0] rs [6];

  always #2.5 clk = ~clk;

  radio_link_frontend u_dut (.*);

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_host(output logic [7:0] b, output logic l);
    int n = 0;
    while (!host_valid && n < 30) begin @(negedge clk); n++; end
    b = host_valid ? host_byte : 8'hxx; l = host_last;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic get_stats();
    logic l;
    send(8'h03);
    for (int i = 0; i < 6; i++) read_host(rs[i], l);
    chk("R6", "last flag on sixth byte", l, 1'b1);
  endtask

  task automatic outcome(input int kind); // 0 ok, 1 busy fail, 2 retry fail
    tx_ok = (kind == 0); tx_fail_busy = (kind == 1); tx_fail_retry = (kind == 2);
    @(negedge clk);
    tx_ok = 0; tx_fail_busy = 0; tx_fail_retry = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "host_valid", host_valid, 0);
    chk("R1", "txq_valid", txq_valid, 0);
    chk("R1", "cfg", {cfg_role, cfg_ack_en, cfg_listen, cfg_netid}, 0);
    chk("R1", "mac", cfg_mac, 0);
  endtask

  task automatic t_config();
    do_reset();
    send(8'h01); send(8'h0E);
    for (int i = 1; i <= 8; i++) send(8'(i * 17));
    send(8'hBE);
    chk("R2", "mac before final byte", cfg_mac, 0);
    chk("R2", "netid before final byte", cfg_netid, 0);
    send(8'hEF); @(negedge clk);
    chk("R2", "role", cfg_role, 2'd2);
    chk("R2", "ack/listen", {cfg_ack_en, cfg_listen}, 2'b11);
    chk("R2", "mac", cfg_mac, 64'h1122334455667788);
    chk("R2", "netid", cfg_netid, 16'hBEEF);
    send(8'h55); send(8'hFF);
    get_stats();
    chk("R3", "response type after junk", rs[0], 8'h04);
    chk("R3", "mac unchanged", cfg_mac, 64'h1122334455667788);
  endtask

  task automatic t_data();
    do_reset();
    send(8'h02); send(8'h03); send(8'hA1); @(negedge clk);
    chk("R4", "txq_valid while partial", txq_valid, 0);
    send(8'hA2); send(8'hA3); @(negedge clk);
    chk("R4", "txq_valid after packet", txq_valid, 1);
    send(8'h02); send(8'h00);
    get_stats();
    chk("R6", "queued packets", rs[2], 1);
    chk("R6", "flags", rs[5], 0);
    for (int i = 0; i < 3; i++) begin
      chk("R4", "payload byte", txq_byte, 8'hA1 + 8'(i));
      chk("R4", "last marker", txq_last, i == 2);
      txq_pop = 1'b1; @(negedge clk); txq_pop = 1'b0;
    end
    chk("R4", "queue empty after drain", txq_valid, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    send(8'h02); send(8'd40); for (int i = 0; i < 40; i++) send(8'(i));
    send(8'h02); send(8'd40); for (int i = 0; i < 40; i++) send(8'(100 + i));
    send(8'h02); send(8'd20); for (int i = 0; i < 20; i++) send(8'(200 + i));
    @(negedge clk);
    get_stats();
    chk("R5", "queued packets after drop", rs[2], 2);
    chk("R5", "overflow flag", rs[5], 1);
    get_stats();
    chk("R5", "flag cleared after report", rs[5], 0);
    for (int i = 0; i < 60; i++) begin
      logic [7:0] e = (i < 40) ? 8'(i) : 8'(200 + i - 40);
      if (txq_byte !== e || txq_last !== (i == 39 || i == 59))
        chk("R5", "kept byte", {txq_last, txq_byte}, {(i == 39 || i == 59), e});
      txq_pop = 1'b1; @(negedge clk); txq_pop = 1'b0;
    end
    chk("R5", "all kept bytes drained", txq_valid, 0);
  endtask

  task automatic t_window();
    do_reset();
    for (int i = 0; i < 254; i++)
      outcome(i == 10 ? 1 : i == 100 ? 2 : i == 200 ? 1 : 0);
    get_stats();
    chk("R7", "window before rollover", rs[1], 0);
    outcome(2);
    get_stats();
    chk("R7", "window at rollover", rs[1], 4);
    outcome(1); outcome(0);
    get_stats();
    chk("R7", "window holds", rs[1], 4);
  endtask

  task automatic t_delay();
    int avg = 0;
    int ds [3] = '{40, 40, 200};
    do_reset();
    for (int k = 0; k < 3; k++) begin
      send(8'h02); send(8'h01); send(8'h5A); @(negedge clk);
      txq_pop = 1'b1; @(negedge clk); txq_pop = 1'b0;
      repeat (ds[k] - 1) @(negedge clk);
      outcome(0);
      avg = (7 * avg + ds[k]) / 8;
      get_stats();
      chk("R8", "average delay", {rs[3], rs[4]}, 64'(avg));
    end
  endtask

  task automatic t_inbound();
    logic [7:0] b; logic l;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      net_valid = 1; net_byte = 8'h31 + 8'(i); net_last = (i == 2);
      @(negedge clk);
    end
    net_valid = 0; net_last = 0;
    read_host(b, l);
    chk("R9", "first network byte", {l, b}, {1'b0, 8'h31});
    send(8'h03); repeat (3) @(negedge clk);
    read_host(b, l);
    chk("R10", "network continues", {l, b}, {1'b0, 8'h32});
    read_host(b, l);
    chk("R9", "network last", {l, b}, {1'b1, 8'h33});
    read_host(b, l);
    chk("R10", "response after packet", b, 8'h04);
    for (int i = 0; i < 5; i++) read_host(b, l);
    chk("R10", "host idle after response", host_valid, 0);
  endtask

  initial begin
    t_reset();
    t_config();
    t_data();
    t_overflow();
    t_window();
    t_delay();
    t_inbound();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule